// File: doc/BRIEF.md
# Non-Posted Tag Association Queue

This block remembers which local context belongs to each outstanding non-posted request when the request tags are handed out later by a downstream tag allocator. The requester pushes a context word (for example a local buffer index) for every non-posted request it issues. The allocator later returns a 6-bit tag for each request on a strobe that is high for one cycle. Tags come back in the same order as the requests went out, but they can arrive several cycles late, and new requests may be issued in the meantime. The pushed contexts therefore wait in an in-order queue. Each tag strobe takes the oldest waiting context and binds it to that tag in a table that is indexed by the tag.

When completion data arrives, the completion path looks up the tag. It gets back the bound context and a hit flag on the next cycle. It can also ask for the entry to be released in the same operation, so that the tag is free for reuse. The block does not handle completion payloads.

The queue depth must be a power of two. The tag width sets the table size to 2^TAG_W entries.

Top module: `np_tag_binder`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `tag_err` is 0 and `lk_done` is 0. Every table entry is empty, so any lookup returns `lk_hit`=0.
- R2: A context is queued when `req_valid` and `req_ready` are both 1 on a clock edge. The queue accepts `Q_DEPTH` (default 64) contexts. `req_ready` is 0 while `Q_DEPTH` contexts are waiting, and a context presented in that state is dropped.
- R3: A cycle with `tag_valid`=1 and a non-empty queue removes the oldest queued context and binds it to table entry `tag_id`. Contexts are therefore bound in the order they were pushed.
- R4: A cycle with `lk_valid`=1 produces, one clock later, `lk_done`=1 together with `lk_hit` and `lk_ctx` for entry `lk_tag`. These reflect the table as it stood before that edge. `lk_done` is 0 in the cycle after a cycle with `lk_valid`=0.
- R5: A lookup of an entry that holds no binding returns `lk_hit`=0. `lk_ctx` has no meaning in that case.
- R6: A lookup with `lk_release`=1 on a bound entry returns that entry's context, then empties the entry, so later lookups of that tag miss. A release on an empty entry changes nothing.
- R7: A bind and a release to the same tag on the same edge leave the entry bound to the new context. The lookup issued in that cycle returns the old binding.
- R8: A `tag_valid` strobe that arrives while the queue is empty sets `tag_err` to 1, binds nothing and leaves the queue unchanged. `tag_err` then stays 1 until reset.
- R9: A push and a tag strobe on the same edge, with a non-empty queue, are both carried out. The strobe binds the oldest context and the new context joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A non-posted request is issued and its context is on `req_ctx` |
| req_ctx | input | CTX_W | Context word to associate with the request |
| req_ready | output | 1 | The queue has room for another context |
| tag_valid | input | 1 | One-cycle strobe: a tag was allocated to the oldest request |
| tag_id | input | TAG_W | The allocated tag |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Tag to look up |
| lk_release | input | 1 | Empty the entry after reading it |
| lk_done | output | 1 | Lookup result valid (one cycle after `lk_valid`) |
| lk_hit | output | 1 | The looked-up entry held a binding |
| lk_ctx | output | CTX_W | Context read from the entry |
| tag_err | output | 1 | Sticky flag: a tag arrived with no context waiting |

## Verification
The main binding function is driven in three ways. A table of eight context/tag pairs is first queued in full and then bound by a burst of strobes, which checks the FIFO order across non-adjacent tags including 0 and 63. A push in the same cycle as a strobe checks that the context being popped is not confused with the one being pushed. A full fill-and-drain of the queue checks the depth limit, that a refused push is not queued, and that the error strobe leaves earlier bindings untouched. Release is tried alone, on an empty entry, and on the same edge as a bind, which separates bind priority from read-before-write lookup timing.

// File: rtl/ntb_pkg.sv
package ntb_pkg;
  localparam int unsigned NTB_TAG_W = 6;
  localparam int unsigned NTB_CTX_W = 16;
  localparam int unsigned NTB_Q_DEPTH = 64;
endpackage

// File: rtl/ntb_ctx_fifo.sv
module ntb_ctx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count)); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1)); // R3
  AST_PUSH_POP_BOTH: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty && !full) |=> ($stable(count) && !$stable(rd_ptr))); // R9
endmodule

// File: rtl/ntb_tag_table.sv
module ntb_tag_table #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned CTX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bind_en,
  input  logic [TAG_W-1:0] bind_tag,
  input  logic [CTX_W-1:0] bind_ctx,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_release,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [CTX_W-1:0] lk_ctx
);
  localparam int unsigned ENTRIES = 1 << TAG_W;

  logic [CTX_W-1:0]   ctx_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic               rel_hit, same_tag;

  assign same_tag = bind_en && (bind_tag == lk_tag);
  assign rel_hit  = lk_valid && lk_release && vld[lk_tag];

  // context storage: one write port, registered read (read-before-write)
  always_ff @(posedge clk) begin
    if (bind_en) ctx_mem[bind_tag] <= bind_ctx;
    if (lk_valid) lk_ctx <= ctx_mem[lk_tag];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
    end else begin
      lk_done <= lk_valid;
      lk_hit  <= lk_valid && vld[lk_tag];
      if (rel_hit && !same_tag) vld[lk_tag] <= 1'b0;
      if (bind_en) vld[bind_tag] <= 1'b1;
    end
  end

  AST_BIND_WINS: assert property (@(posedge clk) disable iff (rst)
    (bind_en && lk_valid && lk_release && same_tag) |=> vld[$past(lk_tag)]); // R7
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rel_hit && !same_tag) |=> !vld[$past(lk_tag)]); // R6
endmodule

// File: rtl/np_tag_binder.sv
module np_tag_binder
  import ntb_pkg::*;
#(
  parameter int unsigned TAG_W = NTB_TAG_W,
  parameter int unsigned CTX_W = NTB_CTX_W,
  parameter int unsigned Q_DEPTH = NTB_Q_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CTX_W-1:0] req_ctx,
  output logic             req_ready,
  input  logic             tag_valid,
  input  logic [TAG_W-1:0] tag_id,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_release,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [CTX_W-1:0] lk_ctx,
  output logic             tag_err
);
  logic             q_full, q_empty, bind_en;
  logic [CTX_W-1:0] q_head;

  assign req_ready = !q_full;
  assign bind_en   = tag_valid && !q_empty;

  ntb_ctx_fifo #(.DEPTH(Q_DEPTH), .W(CTX_W)) ctx_q_i (
    .clk(clk), .rst(rst),
    .push(req_valid), .din(req_ctx),
    .pop(tag_valid), .dout(q_head),
    .full(q_full), .empty(q_empty)
  );

  ntb_tag_table #(.TAG_W(TAG_W), .CTX_W(CTX_W)) table_i (
    .clk(clk), .rst(rst),
    .bind_en(bind_en), .bind_tag(tag_id), .bind_ctx(q_head),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_release(lk_release),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_ctx(lk_ctx)
  );

  always_ff @(posedge clk) begin
    if (rst)                       tag_err <= 1'b0;
    else if (tag_valid && q_empty) tag_err <= 1'b1;
  end

  AST_ERR_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (tag_valid && q_empty) |=> tag_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    tag_err |=> tag_err); // R8
endmodule

// File: tb/np_tag_binder_tb_top.sv
module np_tag_binder_tb_top;
  localparam int unsigned TW = 6;
  localparam int unsigned CW = 16;
  localparam int unsigned QD = 64;
  localparam int NV = 8;
  // each vector: {tag, context}; pushed in order, tags returned in order
  localparam logic [TW+CW-1:0] VEC [NV] = '{
    {6'd0,  16'h1111}, {6'd63, 16'h2222}, {6'd5,  16'h3333}, {6'd17, 16'h4444},
    {6'd33, 16'h5555}, {6'd9,  16'h6666}, {6'd48, 16'h7777}, {6'd2,  16'h8888}};

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, tag_valid = 1'b0, lk_valid = 1'b0, lk_release = 1'b0;
  logic [CW-1:0] req_ctx = '0;
  logic [TW-1:0] tag_id = '0, lk_tag = '0;
  logic req_ready, lk_done, lk_hit, tag_err;
  logic [CW-1:0] lk_ctx;
  int checks = 0, errors = 0;
  logic h;
  logic [CW-1:0] c;

  always #2 clk = ~clk;

  np_tag_binder #(.TAG_W(TW), .CTX_W(CW), .Q_DEPTH(QD)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_ready(req_ready), .tag_valid(tag_valid), .tag_id(tag_id),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_release(lk_release),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_ctx(lk_ctx), .tag_err(tag_err));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [CW-1:0] v);
    req_valid = 1'b1; req_ctx = v; step(); req_valid = 1'b0;
  endtask

  task automatic give_tag(input logic [TW-1:0] t);
    tag_valid = 1'b1; tag_id = t; step(); tag_valid = 1'b0;
  endtask

  task automatic lookup(input logic [TW-1:0] t, input logic rel, output logic hit, output logic [CW-1:0] ctx);
    lk_valid = 1'b1; lk_tag = t; lk_release = rel; step();
    lk_valid = 1'b0; lk_release = 1'b0;
    chk("R4", "lk_done", 32'(lk_done), 32'd1);
    hit = lk_hit; ctx = lk_ctx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "tag_err", 32'(tag_err), 32'd0);
    chk("R1", "lk_done", 32'(lk_done), 32'd0);
    lookup(6'd0, 1'b0, h, c);  chk("R1", "hit tag0", 32'(h), 32'd0);
    lookup(6'd63, 1'b0, h, c); chk("R5", "hit tag63", 32'(h), 32'd0);
    step(); chk("R4", "lk_done idle", 32'(lk_done), 32'd0);

    // R3 vector table: queue all, then bind all, then read back
    for (int i = 0; i < NV; i++) push(VEC[i][CW-1:0]);
    for (int i = 0; i < NV; i++) give_tag(VEC[i][TW+CW-1:CW]);
    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][TW+CW-1:CW], 1'b0, h, c);
      chk("R3", "vec hit", 32'(h), 32'd1);
      chk("R3", "vec ctx", 32'(c), 32'(VEC[i][CW-1:0]));
    end

    // R9 push and pop in the same cycle
    push(16'hA001);
    req_valid = 1'b1; req_ctx = 16'hB002; tag_valid = 1'b1; tag_id = 6'd20;
    step(); req_valid = 1'b0; tag_valid = 1'b0;
    give_tag(6'd21);
    lookup(6'd20, 1'b0, h, c); chk("R9", "tag20 ctx", 32'(c), 32'hA001);
    lookup(6'd21, 1'b0, h, c); chk("R9", "tag21 ctx", 32'(c), 32'hB002);
    chk("R9", "tag21 hit", 32'(h), 32'd1);
    chk("R8", "no err yet", 32'(tag_err), 32'd0);

    // R6 release
    lookup(6'd20, 1'b1, h, c);
    chk("R6", "release read hit", 32'(h), 32'd1);
    chk("R6", "release read ctx", 32'(c), 32'hA001);
    lookup(6'd20, 1'b0, h, c); chk("R6", "after release", 32'(h), 32'd0);
    lookup(6'd40, 1'b1, h, c); chk("R5", "empty tag miss", 32'(h), 32'd0);
    lookup(6'd21, 1'b0, h, c); chk("R6", "other entry kept", 32'(h), 32'd1);

    // R7 bind and release of the same tag on one edge
    push(16'hC0DE);
    tag_valid = 1'b1; tag_id = 6'd5;
    lookup(6'd5, 1'b1, h, c);
    tag_valid = 1'b0;
    chk("R7", "same-cycle old hit", 32'(h), 32'd1);
    chk("R7", "same-cycle old ctx", 32'(c), 32'h3333);
    lookup(6'd5, 1'b0, h, c);
    chk("R7", "bind wins hit", 32'(h), 32'd1);
    chk("R7", "bind wins ctx", 32'(c), 32'hC0DE);

    // R2 fill to depth, refused push, drain
    for (int i = 0; i < QD; i++) begin
      if (req_ready !== 1'b1) chk("R2", "ready while filling", 32'(req_ready), 32'd1);
      push(16'(1000 + i));
    end
    chk("R2", "ready when full", 32'(req_ready), 32'd0);
    push(16'hDEAD);
    chk("R2", "still full", 32'(req_ready), 32'd0);
    for (int i = 0; i < QD; i++) give_tag(6'(i));
    chk("R2", "ready after drain", 32'(req_ready), 32'd1);
    chk("R8", "no err after drain", 32'(tag_err), 32'd0);
    lookup(6'd0, 1'b0, h, c);  chk("R3", "tag0 ctx", 32'(c), 32'd1000);
    lookup(6'd63, 1'b0, h, c); chk("R3", "tag63 ctx", 32'(c), 32'd1063);

    // R8 strobe on empty queue
    give_tag(6'd7);
    chk("R8", "err set", 32'(tag_err), 32'd1);
    lookup(6'd7, 1'b0, h, c);
    chk("R8", "no bind on empty", 32'(c), 32'd1007);
    chk("R2", "refused ctx not queued", 32'(c == 16'hDEAD), 32'd0);
    repeat (5) step();
    chk("R8", "err sticky", 32'(tag_err), 32'd1);
    push(16'h0BAD); give_tag(6'd7);
    lookup(6'd7, 1'b0, h, c); chk("R8", "queue unchanged", 32'(c), 32'h0BAD);

    // R1 reset clears flag and table
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1", "err cleared", 32'(tag_err), 32'd0);
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    lookup(6'd7, 1'b0, h, c); chk("R1", "table cleared", 32'(h), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule